// File: doc/BRIEF.md
# Deferred Peak Value Recorder

This block keeps a running maximum of the measured value for each of several supply rails and rations how often that maximum is pushed to slow, wear-limited persistent storage. Samples arrive as a rail index plus an unsigned value. The latest peak of every rail can be read at all times. Commits leave the block as rail/value pairs on a valid/ready handshake. The storage controller that accepts them is outside the block.

When a rail's peak rises above the value last committed for it, the block starts a hold-off window of a fixed number of one-second ticks for that rail. Further rises during the window only raise the value to be written. When the window ends, the highest value seen is offered once. In brownout mode no windows run. Instead, a power-down detect pulse flags every rail whose peak is above its committed value, and these rails are offered in ascending rail order. With persistent logging switched off, peaks are still tracked but nothing is offered.

Top module: `rail_peak_recorder`

## Requirements
- R1: After reset every readable peak is 0, every committed value is 0 and `cmt_valid` is low.
- R2: A sample whose value exceeds its rail's current peak replaces that peak from the next cycle. A sample at or below the peak leaves it unchanged, and a peak never decreases.
- R3: With logging on and brownout mode off, a rail whose peak exceeds its committed value opens a window in the following cycle. After exactly WIN_TICKS ticks counted in that window (default 30), the rail is offered on the commit port. It is not offered before then.
- R4: The offered value is the highest sample seen for that rail up to the cycle in which its window closes.
- R5: A higher sample that arrives while a window is open raises the pending value and does not restart the window's tick count.
- R6: While `cmt_valid` is high and `cmt_ready` is low, `cmt_valid`, `cmt_rail` and `cmt_value` hold steady.
- R7: A rail's committed value changes only when a handshake for that rail completes. Later samples at or below that value open no window.
- R8: With `log_enable` low, peaks are still tracked, no window opens and no new request is offered.
- R9: With brownout mode on, windows do not run and no offer is made at the end of a tick window. A `pwr_down` pulse flags every rail whose peak is above its committed value. Flagged rails are offered in ascending index order, one per completed handshake. A second pulse with nothing above committed offers nothing.
- R10: A sample that lands in the same cycle as a window's closing tick is not part of that commit. Once the commit is accepted, that sample opens a follow-on window and is committed when that window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_rail | input | IDX_W | Rail index of the sample |
| smp_value | input | VAL_W | Unsigned measured value |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_down | input | 1 | Power-down detect pulse |
| log_enable | input | 1 | Persistent logging enabled |
| brownout_mode | input | 1 | Defer all commits to power-down |
| cmt_valid | output | 1 | Commit request offered |
| cmt_ready | input | 1 | Storage accepts the request |
| cmt_rail | output | IDX_W | Rail of the offered commit |
| cmt_value | output | VAL_W | Value of the offered commit |
| peak_values | output | NUM_RAILS*VAL_W | Current peak per rail, rail 0 in the low bits |

## Verification
The sensitive overlap is a window's closing tick falling in the same cycle as a new, higher sample for that same rail. The bench feeds 29 ticks, then drives the 30th tick and a higher sample on the same clock edge. It expects the older maximum to be offered. After that offer is accepted, it expects a second offer carrying the new sample, exactly one full window later. A second overlap is several rails flagged by one power-down pulse. This case is judged by the order of rails seen across successive handshakes.

// File: rtl/peak_rec_pkg.sv
// Package: shared types for the deferred peak recorder.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package peak_rec_pkg;

    // Commit arbiter states: idle or holding one offered request.
    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_t;

endpackage

// File: rtl/peak_rail_slot.sv
// Module: per-rail peak tracker with a tick-counted hold-off window.
// Keeps the running peak and the last committed value of one rail, runs the
// window, and latches a pending commit value until the arbiter acknowledges it.
// Assumes commit_ack is asserted only while pend_o is high.
module peak_rail_slot #(
    parameter int VAL_W     = 16,
    parameter int WIN_TICKS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_hit,
    input  logic [VAL_W-1:0] smp_val,
    input  logic             tick,
    input  logic             pwr_dn,
    input  logic             log_en,
    input  logic             brown_en,
    input  logic             commit_ack,
    output logic [VAL_W-1:0] peak_o,
    output logic             pend_o,
    output logic [VAL_W-1:0] pend_val_o,
    output logic             win_o
);
    localparam int CNT_W = $clog2(WIN_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WIN_TICKS - 1);

    logic [VAL_W-1:0] peak_q;
    logic [VAL_W-1:0] cmtd_q;
    logic [VAL_W-1:0] pval_q;
    logic             pend_q;
    logic             win_q;
    logic [CNT_W-1:0] cnt_q;
    logic             above;
    logic             arm_ok;
    logic             close_now;
    logic             flush_now;

    // Decode window and flush conditions from current state.
    always_comb begin
        above     = peak_q > cmtd_q;
        arm_ok    = log_en && !brown_en;
        close_now = arm_ok && win_q && tick && (cnt_q == LAST_TICK);
        flush_now = log_en && brown_en && pwr_dn && above && !pend_q;
    end

    // Running peak: raised by any larger sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (smp_hit && (smp_val > peak_q)) begin
            peak_q <= smp_val;
        end
    end

    // Committed value: follows the pending value on acknowledge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmtd_q <= '0;
        end else if (commit_ack) begin
            cmtd_q <= pval_q;
        end
    end

    // Hold-off window: opens when the peak leads the committed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            cnt_q <= '0;
        end else if (!arm_ok) begin
            win_q <= 1'b0;
            cnt_q <= '0;
        end else if (win_q) begin
            if (tick) begin
                if (cnt_q == LAST_TICK) begin
                    win_q <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (above && !pend_q) begin
            win_q <= 1'b1;
            cnt_q <= '0;
        end
    end

    // Pending request: set at window close or power-down flush, cleared on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pval_q <= '0;
        end else if (commit_ack) begin
            pend_q <= 1'b0;
        end else if (close_now || flush_now) begin
            pend_q <= 1'b1;
            pval_q <= peak_q;
        end
    end

    assign peak_o     = peak_q;
    assign pend_o     = pend_q;
    assign pend_val_o = pval_q;
    assign win_o      = win_q;
endmodule

// File: rtl/peak_commit_arb.sv
// Module: ascending-index commit arbiter with a held offer.
// Picks the lowest pending rail, holds it on the port until accepted, then
// returns to idle for one cycle before the next pick.
// Assumes pending values are stable while their pending flag is set.
module peak_commit_arb #(
    parameter int N     = 8,
    parameter int VAL_W = 16,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       pend_vec,
    input  logic [N*VAL_W-1:0] pend_vals,
    input  logic               ready,
    output logic               valid,
    output logic [IDX_W-1:0]   rail,
    output logic [VAL_W-1:0]   value,
    output logic [N-1:0]       ack_vec
);
    import peak_rec_pkg::*;

    arb_state_t       st_q;
    logic [IDX_W-1:0] sel_q;
    logic [IDX_W-1:0] first_idx;
    logic             any_pend;

    // Lowest-index pending rail.
    always_comb begin
        first_idx = '0;
        any_pend  = |pend_vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_vec[i]) first_idx = IDX_W'(i);
        end
    end

    // Offer state: latch a rail when idle, release it on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ARB_IDLE;
            sel_q <= '0;
        end else if (st_q == ARB_IDLE) begin
            if (any_pend) begin
                st_q  <= ARB_OFFER;
                sel_q <= first_idx;
            end
        end else if (ready) begin
            st_q <= ARB_IDLE;
        end
    end

    // Port drive and one-hot acknowledge back to the selected rail.
    always_comb begin
        valid   = (st_q == ARB_OFFER);
        rail    = sel_q;
        value   = pend_vals[sel_q*VAL_W +: VAL_W];
        ack_vec = '0;
        if (valid && ready) ack_vec[sel_q] = 1'b1;
    end
endmodule

// File: rtl/rail_peak_recorder.sv
// Module: top of the deferred peak recorder.
// One peak_rail_slot per rail plus one commit arbiter.
// Assumes sec_tick and pwr_down are single-cycle pulses.
module rail_peak_recorder #(
    parameter int NUM_RAILS = 8,
    parameter int VAL_W     = 16,
    parameter int WIN_TICKS = 30,
    localparam int IDX_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [IDX_W-1:0]           smp_rail,
    input  logic [VAL_W-1:0]           smp_value,
    input  logic                       sec_tick,
    input  logic                       pwr_down,
    input  logic                       log_enable,
    input  logic                       brownout_mode,
    output logic                       cmt_valid,
    input  logic                       cmt_ready,
    output logic [IDX_W-1:0]           cmt_rail,
    output logic [VAL_W-1:0]           cmt_value,
    output logic [NUM_RAILS*VAL_W-1:0] peak_values
);
    logic [NUM_RAILS-1:0]       pend_vec;
    logic [NUM_RAILS-1:0]       ack_vec;
    logic [NUM_RAILS-1:0]       win_vec;
    logic [NUM_RAILS*VAL_W-1:0] pend_vals;

    // One tracker per rail.
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        logic hit;
        assign hit = smp_valid && (smp_rail == IDX_W'(g));
        peak_rail_slot #(
            .VAL_W     (VAL_W),
            .WIN_TICKS (WIN_TICKS)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_hit    (hit),
            .smp_val    (smp_value),
            .tick       (sec_tick),
            .pwr_dn     (pwr_down),
            .log_en     (log_enable),
            .brown_en   (brownout_mode),
            .commit_ack (ack_vec[g]),
            .peak_o     (peak_values[g*VAL_W +: VAL_W]),
            .pend_o     (pend_vec[g]),
            .pend_val_o (pend_vals[g*VAL_W +: VAL_W]),
            .win_o      (win_vec[g])
        );
    end

    peak_commit_arb #(
        .N     (NUM_RAILS),
        .VAL_W (VAL_W),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_vec  (pend_vec),
        .pend_vals (pend_vals),
        .ready     (cmt_ready),
        .valid     (cmt_valid),
        .rail      (cmt_rail),
        .value     (cmt_value),
        .ack_vec   (ack_vec)
    );
endmodule

// File: rtl/peak_rec_checker.sv
// Module: property checker for rail_peak_recorder, attached by bind.
// Observes ports plus the pending vector between slots and arbiter.
module peak_rec_checker #(
    parameter int NUM_RAILS = 8,
    parameter int VAL_W     = 16,
    parameter int IDX_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pwr_down,
    input logic                       log_enable,
    input logic                       brownout_mode,
    input logic                       cmt_valid,
    input logic                       cmt_ready,
    input logic [IDX_W-1:0]           cmt_rail,
    input logic [VAL_W-1:0]           cmt_value,
    input logic [NUM_RAILS*VAL_W-1:0] peak_values,
    input logic [NUM_RAILS-1:0]       pend_vec
);
    // Mask of rails with a lower index than r.
    function automatic logic [NUM_RAILS-1:0] below(input logic [IDX_W-1:0] r);
        below = '0;
        for (int i = 0; i < NUM_RAILS; i++) begin
            if (i < int'(r)) below[i] = 1'b1;
        end
    endfunction

    assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid && !cmt_ready |=> cmt_valid && $stable(cmt_rail) && $stable(cmt_value));

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !log_enable && !cmt_valid && (pend_vec == '0) |=> !cmt_valid);

    assert_ascending_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmt_valid) |-> (($past(pend_vec) & below(cmt_rail)) == '0));

    assert_no_timed_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(brownout_mode) && !$past(pwr_down) |-> ((pend_vec & ~$past(pend_vec)) == '0));

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_mono
        assert_peak_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
            peak_values[i*VAL_W +: VAL_W] >= $past(peak_values[i*VAL_W +: VAL_W]));
    end
endmodule

bind rail_peak_recorder peak_rec_checker #(
    .NUM_RAILS (NUM_RAILS),
    .VAL_W     (VAL_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_down      (pwr_down),
    .log_enable    (log_enable),
    .brownout_mode (brownout_mode),
    .cmt_valid     (cmt_valid),
    .cmt_ready     (cmt_ready),
    .cmt_rail      (cmt_rail),
    .cmt_value     (cmt_value),
    .peak_values   (peak_values),
    .pend_vec      (pend_vec)
);

// File: tb/sim_rail_peak_recorder.sv
// Bench: directed scenarios for rail_peak_recorder, one task each.
module sim_rail_peak_recorder;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int IW = 3;
    localparam int WT = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [IW-1:0] smp_rail = '0;
    logic [W-1:0]  smp_value = '0;
    logic          sec_tick = 1'b0;
    logic          pwr_down = 1'b0;
    logic          log_enable = 1'b0;
    logic          brownout_mode = 1'b0;
    logic          cmt_ready = 1'b0;
    logic          cmt_valid;
    logic [IW-1:0] cmt_rail;
    logic [W-1:0]  cmt_value;
    logic [N*W-1:0] peak_values;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rail_peak_recorder #(.NUM_RAILS(N), .VAL_W(W), .WIN_TICKS(WT)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_rail(smp_rail),
        .smp_value(smp_value), .sec_tick(sec_tick), .pwr_down(pwr_down),
        .log_enable(log_enable), .brownout_mode(brownout_mode),
        .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_rail(cmt_rail),
        .cmt_value(cmt_value), .peak_values(peak_values)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sample(input int r, input int v);
        @(negedge clk);
        smp_valid = 1'b1; smp_rail = IW'(r); smp_value = W'(v);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Each tick: pulse, then one idle cycle.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
        idle(1);
    endtask

    task automatic take(input string req, input int r, input int v);
        for (int i = 0; i < 20 && !cmt_valid; i++) @(negedge clk);
        chk(req, 32'(cmt_valid), 1);
        chk(req, 32'(cmt_rail), r);
        chk(req, 32'(cmt_value), v);
        cmt_ready = 1'b1;
        @(negedge clk);
        cmt_ready = 1'b0;
    endtask

    function automatic int peak_of(input int r);
        return int'(peak_values[r*W +: W]);
    endfunction

    task automatic t_reset();
        chk("R1 valid", 32'(cmt_valid), 0);
        for (int r = 0; r < N; r++) chk("R1 peak", peak_of(r), 0);
    endtask

    task automatic t_window();
        log_enable = 1'b1;
        sample(3, 100);
        chk("R2 rise", peak_of(3), 100);
        sample(3, 50);
        chk("R2 lower ignored", peak_of(3), 100);
        ticks(10);
        sample(3, 200);
        ticks(19);
        chk("R3/R5 no offer after 29 ticks", 32'(cmt_valid), 0);
        ticks(1);
        chk("R3 offer at window end", 32'(cmt_valid), 1);
        chk("R4 window max", 32'(cmt_value), 200);
        idle(5);
        chk("R6 held valid", 32'(cmt_valid), 1);
        chk("R6 held rail", 32'(cmt_rail), 3);
        chk("R6 held value", 32'(cmt_value), 200);
        take("R3 accept", 3, 200);
        idle(2);
        chk("R3 cleared", 32'(cmt_valid), 0);
    endtask

    task automatic t_committed();
        sample(3, 200);
        sample(3, 150);
        ticks(WT + 3);
        chk("R7 no window at committed", 32'(cmt_valid), 0);
        sample(3, 250);
        ticks(WT - 1);
        chk("R7 not yet", 32'(cmt_valid), 0);
        ticks(1);
        take("R7 new commit", 3, 250);
    endtask

    task automatic t_overlap();
        sample(1, 500);
        ticks(WT - 1);
        @(negedge clk);
        sec_tick = 1'b1; smp_valid = 1'b1; smp_rail = 3'd1; smp_value = 16'd600;
        @(negedge clk);
        sec_tick = 1'b0; smp_valid = 1'b0;
        idle(1);
        take("R10 closing commit excludes same-cycle sample", 1, 500);
        chk("R10 peak holds new sample", peak_of(1), 600);
        ticks(WT - 1);
        chk("R10 follow-on not early", 32'(cmt_valid), 0);
        ticks(1);
        take("R10 follow-on commit", 1, 600);
    endtask

    task automatic t_log_off();
        log_enable = 1'b0;
        sample(6, 900);
        chk("R8 peak tracked", peak_of(6), 900);
        ticks(WT + 5);
        chk("R8 no offer", 32'(cmt_valid), 0);
    endtask

    task automatic t_brownout();
        brownout_mode = 1'b1;
        idle(1);
        log_enable = 1'b1;
        sample(5, 400);
        sample(2, 300);
        ticks(WT + 5);
        chk("R9 no timed offer", 32'(cmt_valid), 0);
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        take("R9 first rail 2", 2, 300);
        take("R9 second rail 5", 5, 400);
        take("R9 third rail 6", 6, 900);
        idle(6);
        chk("R9 nothing else", 32'(cmt_valid), 0);
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        idle(6);
        chk("R9 second pulse quiet", 32'(cmt_valid), 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_window();
        t_committed();
        t_overlap();
        t_log_off();
        t_brownout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule